// File: doc/BRIEF.md
# Addressable Serial Receiver-Transmitter

This block is a full-duplex asynchronous serial port driven through a small register interface. A transmitter turns a written byte into a framed bit stream on its output line. A receiver rebuilds incoming frames into characters and flags them for software. Both sides share one frame setting: 7, 8 or 9 data bits, an optional even or odd parity bit after the data, and one or two stop bits on the transmit side. The bit period is a fixed divider of the system clock. The receiver takes one sample in the middle of each bit.

For multi-drop buses the receiver has an attention state. While it is set, the receiver keeps following the line but quietly drops every 9-bit character whose top bit is 0. The first character whose top bit is 1 counts as an address. The receiver stores it, raises the buffer-full flag and interrupt, and clears the attention state by itself. Software reads the address and either lets the following characters through or sets attention again.

A loopback setting routes the transmitter into the receiver inside the block and holds the external output line high. In loopback the frame always uses 9 data bits without parity.

Top module: `uart_mp`

## Requirements
- R1: After reset the serial output is high, the interrupt is low, and the control register (address 2) and status register (address 3) both read 0.
- R2: A transmitted frame is one low start bit, the data bits least significant first, the optional parity bit, then one stop bit, or two when control bit 3 is set, all high. Every bit lasts CLKS_PER_BIT clocks. Control bit 0 selects 8 data bits (1) or 7 data bits (0).
- R3: Control bit 1 enables a parity bit and control bit 2 makes it odd (1) or even (0). Parity counts only the data bits of the frame, on both transmit and receive.
- R4: Control bit 4 selects 9 data bits with no parity. The transmitted ninth bit is control bit 5. The received ninth bit appears as bit 8 of the receive-data register (address 1) and as status bit 4.
- R5: A completed character is stored in the receive-data register and sets status bit 0 (buffer full). A read of address 1 clears that bit.
- R6: A character accepted while status bit 0 is still set (and not being read in the same cycle) sets sticky status bit 3 (overrun) and replaces the buffer. Writing 1 to status bit 3 clears it.
- R7: A parity mismatch or a low stop bit on an accepted character sets sticky status bit 2. Writing 1 to status bit 2 clears it.
- R8: While control bit 8 (attention) is set, a received character whose ninth bit is 0 leaves the buffer, status and control unchanged.
- R9: While attention is set, a character whose ninth bit is 1 is stored like any other character and clears control bit 8. Later characters are then accepted normally.
- R10: The interrupt output is high one clock after buffer full is set while control bit 7 is set, and low one clock after either is cleared.
- R11: With control bit 6 set, the transmitter feeds the receiver internally. The frame is forced to 9 data bits without parity, the output pin stays high, and the input pin is ignored.
- R12: Writing address 0 starts a transmission only while status bit 1 (busy) is clear. A write while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 transmit, 1 receive data, 2 control, 3 status |
| wdata_i | input | 9 | Write data |
| rdata_o | output | 9 | Read data, registered one clock after the read strobe |
| rxd_i | input | 1 | Serial input line |
| txd_o | output | 1 | Serial output line, registered |
| irq_o | output | 1 | Receive interrupt, registered |

## Verification
The bench builds the block with CLKS_PER_BIT set to 8. That keeps the longest frame near a hundred clocks, so every frame width, both parity senses, two stop bits, the attention hand-off and loopback all fit in one short run. With a half-bit delay of 4 clocks, the bench's mid-bit sampling and its cycle-stepped line driving sit well clear of bit edges. Breaking the bit order, the parity sense or the attention clear therefore shows up as a wrong bit, not as a timing slip.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;

  localparam int REG_W  = 9;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_TX   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RX   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  // control register bit positions
  localparam int CB_LEN8  = 0;
  localparam int CB_PAREN = 1;
  localparam int CB_PODD  = 2;
  localparam int CB_STOP2 = 3;
  localparam int CB_NINE  = 4;
  localparam int CB_TXB9  = 5;
  localparam int CB_DIAG  = 6;
  localparam int CB_IRQEN = 7;
  localparam int CB_ATTN  = 8;

  // status register bit positions
  localparam int SB_FULL = 0;
  localparam int SB_BUSY = 1;
  localparam int SB_ERR  = 2;
  localparam int SB_OVR  = 3;
  localparam int SB_RB9  = 4;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } frame_cfg_t;

  // Loopback forces the 9-bit format, and the 9-bit format carries no parity.
  function automatic frame_cfg_t cfg_from_ctrl(input logic [REG_W-1:0] c);
    frame_cfg_t f;
    logic nine;
    nine       = c[CB_NINE] | c[CB_DIAG];
    f.nbits    = nine ? 4'd9 : (c[CB_LEN8] ? 4'd8 : 4'd7);
    f.par_en   = c[CB_PAREN] & ~nine;
    f.par_odd  = c[CB_PODD];
    f.two_stop = c[CB_STOP2];
    return f;
  endfunction

endpackage

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
  import uart_mp_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  frame_cfg_t cfg,
  input  logic       start,
  input  logic [8:0] data,
  output logic       busy,
  output logic       line
);

  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;

  tx_st_t     st;
  logic [CW-1:0] cnt;
  logic [3:0] bitn;
  logic [8:0] sh;
  logic       par;
  frame_cfg_t cfg_q;

  assign busy = (st != T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= T_IDLE;
      line  <= 1'b1;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      par   <= 1'b0;
      cfg_q <= '0;
    end else if (st == T_IDLE) begin
      line <= 1'b1;
      if (start) begin
        cfg_q <= cfg;
        sh    <= data;
        st    <= T_START;
        line  <= 1'b0;
        cnt   <= FULL;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      cnt <= FULL;
      unique case (st)
        T_START: begin
          line <= sh[0];
          par  <= cfg_q.par_odd ^ sh[0];
          sh   <= sh >> 1;
          bitn <= 4'd1;
          st   <= T_DATA;
        end
        T_DATA: begin
          if (bitn == cfg_q.nbits) begin
            bitn <= '0;
            if (cfg_q.par_en) begin
              line <= par;
              st   <= T_PAR;
            end else begin
              line <= 1'b1;
              st   <= T_STOP;
            end
          end else begin
            line <= sh[0];
            par  <= par ^ sh[0];
            sh   <= sh >> 1;
            bitn <= bitn + 1'b1;
          end
        end
        T_PAR: begin
          line <= 1'b1;
          st   <= T_STOP;
        end
        T_STOP: begin
          if (cfg_q.two_stop && bitn == '0) bitn <= 4'd1;
          else                              st   <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R2: a frame opens with a low start bit and closes on a high stop bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !line);
  p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> line);

endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_in,
  input  logic [3:0] nbits,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output logic [8:0] data,
  output logic       err
);

  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_BRK} rx_st_t;

  rx_st_t     st;
  logic       s1, s2;
  logic [CW-1:0] cnt;
  logic [3:0] bitn;
  logic [3:0] nb_q;
  logic       pe_q;
  logic [8:0] sh;
  logic       par;
  logic       perr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= R_IDLE;
      s1   <= 1'b1;
      s2   <= 1'b1;
      cnt  <= '0;
      bitn <= '0;
      nb_q <= '0;
      pe_q <= 1'b0;
      sh   <= '0;
      par  <= 1'b0;
      perr <= 1'b0;
      done <= 1'b0;
      data <= '0;
      err  <= 1'b0;
    end else begin
      s1   <= rx_in;
      s2   <= s1;
      done <= 1'b0;
      unique case (st)
        R_IDLE: begin
          if (!s2) begin
            st   <= R_START;
            cnt  <= HALF;
            nb_q <= nbits;
            pe_q <= par_en;
            par  <= par_odd;
            perr <= 1'b0;
            bitn <= '0;
            sh   <= '0;
          end
        end
        R_BRK: begin
          if (s2) st <= R_IDLE;
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cnt <= FULL;
            case (st)
              R_START: st <= s2 ? R_IDLE : R_DATA;
              R_DATA: begin
                sh   <= {s2, sh[8:1]};
                par  <= par ^ s2;
                bitn <= bitn + 1'b1;
                if (bitn == nb_q - 4'd1) st <= pe_q ? R_PAR : R_STOP;
              end
              R_PAR: begin
                perr <= (s2 != par);
                st   <= R_STOP;
              end
              R_STOP: begin
                done <= 1'b1;
                err  <= perr | !s2;
                unique case (nb_q)
                  4'd7:    data <= {2'b00, sh[8:2]};
                  4'd8:    data <= {1'b0, sh[8:1]};
                  default: data <= sh;
                endcase
                st <= s2 ? R_IDLE : R_BRK;
              end
              default: st <= R_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R5: each completed character is reported by a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/uart_mp.sv
module uart_mp
  import uart_mp_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_o
);

  logic [REG_W-1:0] ctrl_q;
  logic [8:0]       rxbuf_q;
  logic             rx_full_q, err_q, ovr_q;
  frame_cfg_t       cfg;
  logic             tx_busy, tx_line, tx_start;
  logic [8:0]       tx_data;
  logic             rx_in, rx_done, rx_err, accept, rx_take;
  logic [8:0]       rx_data;
  logic [REG_W-1:0] status, rd_mux;

  assign cfg      = cfg_from_ctrl(ctrl_q);
  assign tx_start = wr_i && (addr_i == A_TX) && !tx_busy;
  assign tx_data  = {ctrl_q[CB_TXB9], wdata_i[7:0]};
  assign rx_in    = ctrl_q[CB_DIAG] ? tx_line : rxd_i;
  assign rx_take  = rd_i && (addr_i == A_RX);
  // in attention state only characters with the ninth bit set get through
  assign accept   = rx_done && !(ctrl_q[CB_ATTN] && !rx_data[8]);

  always_comb begin
    status           = '0;
    status[SB_FULL]  = rx_full_q;
    status[SB_BUSY]  = tx_busy;
    status[SB_ERR]   = err_q;
    status[SB_OVR]   = ovr_q;
    status[SB_RB9]   = rxbuf_q[8];
    unique case (addr_i)
      A_RX:    rd_mux = rxbuf_q;
      A_CTRL:  rd_mux = ctrl_q;
      A_STAT:  rd_mux = status;
      default: rd_mux = '0;
    endcase
  end

  uart_mp_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .cfg   (cfg),
    .start (tx_start),
    .data  (tx_data),
    .busy  (tx_busy),
    .line  (tx_line)
  );

  uart_mp_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .rx_in   (rx_in),
    .nbits   (cfg.nbits),
    .par_en  (cfg.par_en),
    .par_odd (cfg.par_odd),
    .done    (rx_done),
    .data    (rx_data),
    .err     (rx_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      rxbuf_q   <= '0;
      rx_full_q <= 1'b0;
      err_q     <= 1'b0;
      ovr_q     <= 1'b0;
      rdata_o   <= '0;
      irq_o     <= 1'b0;
      txd_o     <= 1'b1;
    end else begin
      txd_o <= ctrl_q[CB_DIAG] | tx_line;
      irq_o <= rx_full_q & ctrl_q[CB_IRQEN];
      if (rd_i) rdata_o <= rd_mux;
      if (rx_take) rx_full_q <= 1'b0;
      if (wr_i) begin
        unique case (addr_i)
          A_CTRL: ctrl_q <= wdata_i;
          A_STAT: begin
            if (wdata_i[SB_ERR]) err_q <= 1'b0;
            if (wdata_i[SB_OVR]) ovr_q <= 1'b0;
          end
          default: ;
        endcase
      end
      // receive events take priority over software clears in the same cycle
      if (accept) begin
        rxbuf_q   <= rx_data;
        rx_full_q <= 1'b1;
        if (rx_full_q && !rx_take) ovr_q <= 1'b1;
        if (rx_err) err_q <= 1'b1;
        if (ctrl_q[CB_ATTN]) ctrl_q[CB_ATTN] <= 1'b0;
      end
    end
  end

  // R8: non-address characters in attention state leave the buffer empty
  p_discard_r8: assert property (@(posedge clk) disable iff (rst)
    rx_done && ctrl_q[CB_ATTN] && !rx_data[8] && !rx_full_q |=> !rx_full_q);
  // R9: an address character is buffered and drops the attention state
  p_attn_clear_r9: assert property (@(posedge clk) disable iff (rst)
    rx_done && ctrl_q[CB_ATTN] && rx_data[8] |=> !ctrl_q[CB_ATTN] && rx_full_q);
  // R6: acceptance on a full buffer flags overrun
  p_overrun_r6: assert property (@(posedge clk) disable iff (rst)
    accept && rx_full_q && !rx_take |=> ovr_q);
  // R7: the error flag is sticky until software clears it
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_q && !(wr_i && addr_i == A_STAT && wdata_i[SB_ERR]) |=> err_q);
  // R10: the interrupt follows buffer full by one clock
  p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(rx_full_q));
  p_irq_drop_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_full_q |=> !irq_o);
  // R11: loopback keeps the external line idle
  p_diag_pin_r11: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_q[CB_DIAG]) |-> txd_o);

endmodule

// File: tb/uart_mp_tb.sv
`timescale 1ns/1ps
module uart_mp_tb;

  localparam int CPB = 8;
  localparam logic [1:0] RG_TX = 2'd0, RG_RX = 2'd1, RG_CTRL = 2'd2, RG_STAT = 2'd3;

  typedef struct packed {
    logic [15:0] bits;
    logic [4:0]  len;
  } frm_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [8:0] wdata = '0;
  logic [8:0] rdata;
  logic       rxd = 1'b1;
  logic       txd, irq;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;
  frm_t       txq[$];

  always #2.5 clk = ~clk;

  uart_mp #(.CLKS_PER_BIT(CPB)) u_dut (
    .clk(clk), .rst(rst), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk9(input string tag, input logic [8:0] act, input logic [8:0] exp);
    chk(tag, {7'd0, act}, {7'd0, exp});
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    chk(tag, {15'd0, act}, {15'd0, exp});
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [8:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic frm_t mk(input logic [8:0] d, input int nb, input bit pe,
                              input bit po, input bit ts);
    frm_t f;
    int   n;
    logic p;
    f.bits = '0;
    n = 1;
    p = po;
    for (int i = 0; i < nb; i++) begin
      f.bits[n] = d[i];
      p = p ^ d[i];
      n++;
    end
    if (pe) begin
      f.bits[n] = p;
      n++;
    end
    f.bits[n] = 1'b1;
    n++;
    if (ts) begin
      f.bits[n] = 1'b1;
      n++;
    end
    f.len = 5'(n);
    return f;
  endfunction

  task automatic send_rx(input logic [8:0] d, input int nb, input bit pe, input bit po,
                         input bit bad_par, input bit bad_stop);
    logic p;
    p = po;
    @(negedge clk);
    rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      p = p ^ d[i];
      repeat (CPB) @(negedge clk);
    end
    if (pe) begin
      rxd = bad_par ? ~p : p;
      repeat (CPB) @(negedge clk);
    end
    rxd = bad_stop ? 1'b0 : 1'b1;
    repeat (CPB) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * CPB) @(negedge clk);
  endtask

  task automatic wait_tx();
    logic [8:0] s;
    do bus_rd(RG_STAT, s); while (s[1]);
    repeat (2 * CPB) @(negedge clk);
  endtask

  // monitor: decodes frames on the output line and compares them with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        frm_t        e;
        logic [15:0] got;
        int          len;
        got = '0;
        if (txq.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R12: actual=unexpected frame expected=no frame");
          e = '0;
          len = 1;
        end else begin
          e = txq.pop_front();
          len = int'(e.len);
        end
        repeat (CPB / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < len; i++) begin
          repeat (CPB) @(negedge clk);
          got[i] = txd;
        end
        if (len > 1) chk("R2/R3/R4 tx frame bits", got, e.bits);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk1("R1 txd idle", txd, 1'b1);
    chk1("R1 irq low", irq, 1'b0);
    bus_rd(RG_STAT, v); chk9("R1 status", v, 9'h000);
    bus_rd(RG_CTRL, v); chk9("R1 ctrl", v, 9'h000);

    // R2 8 data bits, one stop; R12 second write while busy is dropped
    bus_wr(RG_CTRL, 9'h001);
    txq.push_back(mk(9'h0A5, 8, 1'b0, 1'b0, 1'b0));
    bus_wr(RG_TX, 9'h0A5);
    bus_rd(RG_STAT, v); chk1("R12 busy after start", v[1], 1'b1);
    bus_wr(RG_TX, 9'h03C);
    wait_tx();

    // R3 7 data bits, even parity, two stops
    bus_wr(RG_CTRL, 9'h00A);
    txq.push_back(mk(9'h057, 7, 1'b1, 1'b0, 1'b1));
    bus_wr(RG_TX, 9'h057);
    wait_tx();

    // R3 8 data bits, odd parity
    bus_wr(RG_CTRL, 9'h007);
    txq.push_back(mk(9'h00F, 8, 1'b1, 1'b1, 1'b0));
    bus_wr(RG_TX, 9'h00F);
    wait_tx();

    // R4 9-bit transmit, ninth bit from control bit 5
    bus_wr(RG_CTRL, 9'h031);
    txq.push_back(mk(9'h181, 9, 1'b0, 1'b0, 1'b0));
    bus_wr(RG_TX, 9'h081);
    wait_tx();

    // R5 and R10 plain receive with interrupt enabled
    bus_wr(RG_CTRL, 9'h081);
    send_rx(9'h05A, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    chk1("R10 irq raised", irq, 1'b1);
    bus_rd(RG_STAT, v); chk1("R5 buffer full set", v[0], 1'b1);
    bus_rd(RG_RX, v); chk9("R5 received data", v, 9'h05A);
    bus_rd(RG_STAT, v); chk1("R5 buffer full cleared by read", v[0], 1'b0);
    chk1("R10 irq dropped", irq, 1'b0);

    // R3 and R7 receive with odd parity, then a parity error
    bus_wr(RG_CTRL, 9'h006);
    send_rx(9'h033, 7, 1'b1, 1'b1, 1'b0, 1'b0);
    bus_rd(RG_RX, v); chk9("R3 7-bit odd parity data", v, 9'h033);
    bus_rd(RG_STAT, v); chk1("R7 no error on good parity", v[2], 1'b0);
    send_rx(9'h033, 7, 1'b1, 1'b1, 1'b1, 1'b0);
    bus_rd(RG_STAT, v); chk1("R7 parity error flagged", v[2], 1'b1);
    bus_wr(RG_STAT, 9'h004);
    bus_rd(RG_STAT, v); chk1("R7 error cleared", v[2], 1'b0);
    bus_rd(RG_RX, v);

    // R7 low stop bit
    bus_wr(RG_CTRL, 9'h001);
    send_rx(9'h011, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    bus_rd(RG_STAT, v); chk1("R7 stop error flagged", v[2], 1'b1);
    bus_wr(RG_STAT, 9'h004);
    bus_rd(RG_RX, v); chk9("R7 data kept on stop error", v, 9'h011);

    // R6 overrun
    send_rx(9'h001, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    send_rx(9'h002, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_rd(RG_STAT, v); chk1("R6 overrun set", v[3], 1'b1);
    bus_rd(RG_RX, v); chk9("R6 newest data kept", v, 9'h002);
    bus_wr(RG_STAT, 9'h008);
    bus_rd(RG_STAT, v); chk1("R6 overrun cleared", v[3], 1'b0);

    // R8 and R9 attention state
    bus_wr(RG_CTRL, 9'h111);
    send_rx(9'h044, 9, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_rd(RG_STAT, v); chk9("R8 status untouched by data char", v, 9'h000);
    bus_rd(RG_CTRL, v); chk1("R8 attention still set", v[8], 1'b1);
    send_rx(9'h107, 9, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_rd(RG_STAT, v); chk1("R9 address buffered", v[0], 1'b1);
    chk1("R4 status ninth bit", v[4], 1'b1);
    bus_rd(RG_CTRL, v); chk1("R9 attention cleared", v[8], 1'b0);
    bus_rd(RG_RX, v); chk9("R9 address data", v, 9'h107);
    send_rx(9'h099, 9, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_rd(RG_STAT, v); chk1("R4 status ninth bit low", v[4], 1'b0);
    bus_rd(RG_RX, v); chk9("R9 following char accepted", v, 9'h099);

    // R11 loopback with parity requested but forced off, input pin held low
    bus_wr(RG_CTRL, 9'h062);
    rxd = 1'b0;
    bus_wr(RG_TX, 9'h03C);
    repeat (5 * CPB) @(negedge clk);
    chk1("R11 output pin idle in loopback", txd, 1'b1);
    wait_tx();
    rxd = 1'b1;
    repeat (2 * CPB) @(negedge clk);
    bus_rd(RG_RX, v); chk9("R11 looped data", v, 9'h13C);
    bus_rd(RG_STAT, v); chk1("R11 no error in loopback", v[2], 1'b0);

    chk("R12 every expected frame seen", 16'(txq.size()), 16'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule